// File: doc/BRIEF.md
# Byte-Wide SPI Port with Register Control

This block is a one-byte serial peripheral interface port for a small 8-bit controller. Software talks to it through three byte-wide registers on a simple read/write strobe bus: a control register, a status register and a data location. A write to the data location loads the transmit byte. A read of the data location returns the receive buffer. The port can act as the clock master, with a programmable divider, or as a slave that follows an external SCK.

A transfer starts when software writes the control register with the enable and go bits both set. The go bit then reads 1 until the eighth bit has been sampled, and hardware clears it. The received byte moves into a separate receive buffer and raises a full flag. In slave mode a byte that completes while the buffer is still unread raises an overflow flag, and that byte is dropped. One control bit picks the SCK idle level and so which edge launches data and which edge samples it. The data is sent MSB first.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0x00. SCK is not driven, SDO is not driven, and the open-drain output is 0.
- R2: In master mode a rate field of r gives an SCK half period of 2^r system clocks, so SCK is the system clock divided by 2^(r+1). A byte uses 16 SCK edges, and SDO carries the transmit byte MSB first. Each bit is valid at its sampling edge.
- R3: Control bit 7 sets the SCK idle level: 0 means idle low, launch on the rising edge and sample on the falling edge; 1 means idle high, launch on the falling edge and sample on the rising edge. SCK sits at the idle level between transfers.
- R4: Control bit 4 (go) reads 1 while a byte is in progress and returns to 0 once the eighth sampling edge has passed.
- R5: With control bit 6 (enable) at 0, a write with go set starts nothing, go reads 0, and neither SCK nor SDO is driven.
- R6: At the end of a byte the received value goes into the receive buffer and status bit 0 (full) becomes 1. A read of the data location (address 2) clears full. Status bit 0 cannot be written, and status bit 1 always reads 0.
- R7: In slave mode, a byte that completes while full is 1 sets control bit 5 (overflow) and leaves the buffer unchanged. Writing control bit 5 as 0 clears the flag without touching the buffer. In master mode the buffer is overwritten and no overflow is raised.
- R8: A write to the data location while a byte is in progress is ignored.
- R9: Control bit 3 (hold) at 0 releases SDO whenever the port is idle. At 1, SDO stays driven while the port is enabled.
- R10: Status bit 7 at 0 selects slave mode. In slave mode SCK and SDI pass through a synchronizer, the port exchanges a byte on the external clock, and the rate field (control bits 2:0) has no effect.
- R11: Status bit 2 is read/write and appears on the SCK open-drain enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (a read of address 2 clears full) |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_out | output | 1 | SCK value in master mode |
| sck_out_en | output | 1 | SCK drive enable |
| sck_opendrain | output | 1 | Open-drain mode request for the SCK pad |
| sck_in | input | 1 | External SCK in slave mode |
| sdo_out | output | 1 | Serial data out |
| sdo_out_en | output | 1 | SDO drive enable |
| sdi_in | input | 1 | Serial data in |

## Verification
The bound checker watches, on every cycle, the rules that link the transfer state to the flags. SCK must rest at the selected idle level while idle. Go must clear after the byte completes. Full must follow every completed byte. Overflow must never appear in master mode, and it may rise only when the buffer is full. Clearing the enable must stop a transfer. Other behaviour can only be shown by the bench's scenarios, because it depends on full byte exchanges. These cover the exact SCK half period for each rate, MSB-first order on the launch edge, the received value in loopback and from a driven slave clock, and the dropped byte after an overflow. They also cover the ignored data write during a transfer and the register readback masks.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int REG_W    = 8;
    localparam int RATE_W   = 3;
    localparam int HALF_W   = (1 << RATE_W) - 1;
    localparam int BITCNT_W = $clog2(REG_W);

    // status bit positions decoded by software
    localparam int ST_MASTER = 7;
    localparam int ST_OD     = 2;
    localparam int ST_FULL   = 0;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              edge_sel;
        logic              enable;
        logic              ovf;
        logic              go;
        logic              hold;
        logic [RATE_W-1:0] rate;
    } ctrl_view_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } sck_event_t;

    function automatic logic [HALF_W-1:0] half_limit(input logic [RATE_W-1:0] r);
        return HALF_W'((32'd1 << r) - 32'd1);
    endfunction

endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_port_pkg::*;
#(
    parameter int RW = RATE_W,
    localparam int CW = (1 << RW) - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [RW-1:0] rate,
    output logic          tick
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = half_limit(rate);
        tick = run && (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_port_pkg::*;
#(
    parameter int DW     = REG_W,
    parameter int SYNC_N = 2,
    localparam int BW    = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          master,
    input  logic          edge_sel,
    input  logic          start,
    input  logic          start_edge,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          tick,
    input  logic          sck_pin,
    input  logic          sdi_pin,
    output logic          busy,
    output logic          sck_lvl,
    output logic          sdo_bit,
    output logic          done,
    output logic [DW-1:0] rx_next
);

    logic [SYNC_N-1:0] sck_sy;
    logic [SYNC_N-1:0] sdi_sy;
    logic              sck_seen;
    logic              sck_s;
    logic              sdi_eff;
    logic              slave_chg;
    logic [DW-1:0]     shreg;
    logic [BW-1:0]     bit_idx;
    sck_event_t        ev;

    always_comb begin
        sck_s     = sck_sy[SYNC_N-1];
        slave_chg = sck_s != sck_seen;
        ev        = '0;
        if (busy && enable) begin
            if (master) begin
                ev.lead  = tick && (sck_lvl == edge_sel);
                ev.trail = tick && (sck_lvl != edge_sel);
            end else begin
                ev.lead  = slave_chg && (sck_s != edge_sel);
                ev.trail = slave_chg && (sck_s == edge_sel);
            end
        end
        sdi_eff = master ? sdi_pin : sdi_sy[SYNC_N-1];
        rx_next = {shreg[DW-2:0], sdi_eff};
        done    = ev.trail && (bit_idx == BW'(DW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sy   <= '0;
            sdi_sy   <= '0;
            sck_seen <= 1'b0;
            busy     <= 1'b0;
            sck_lvl  <= 1'b0;
            sdo_bit  <= 1'b0;
            shreg    <= '0;
            bit_idx  <= '0;
        end else begin
            sck_sy   <= {sck_sy[SYNC_N-2:0], sck_pin};
            sdi_sy   <= {sdi_sy[SYNC_N-2:0], sdi_pin};
            sck_seen <= sck_s;
            if (load && !busy) begin
                shreg <= load_data;
            end
            if (!enable) begin
                busy    <= start;
                sck_lvl <= start ? start_edge : edge_sel;
                bit_idx <= '0;
            end else if (!busy) begin
                sck_lvl <= start ? start_edge : edge_sel;
                if (start) begin
                    busy    <= 1'b1;
                    bit_idx <= '0;
                end
            end else begin
                if (master && tick) begin
                    sck_lvl <= !sck_lvl;
                end
                if (ev.lead) begin
                    sdo_bit <= shreg[DW-1];
                end
                if (ev.trail) begin
                    shreg   <= rx_next;
                    bit_idx <= bit_idx + 1'b1;
                    if (done) begin
                        busy <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [REG_W-1:0]  rx_next,
    output logic              edge_sel,
    output logic              enable,
    output logic              hold,
    output logic [RATE_W-1:0] rate,
    output logic              master,
    output logic              od,
    output logic              rx_full,
    output logic              ovf,
    output logic              start,
    output logic              start_edge,
    output logic              load,
    output logic [REG_W-1:0]  rdata
);

    reg_sel_e         sel;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             rd_data;
    logic [REG_W-1:0] rx_q;
    ctrl_view_t       ctrl_rd;

    always_comb begin
        sel        = reg_sel_e'(addr);
        wr_ctrl    = we && (sel == SEL_CTRL);
        wr_stat    = we && (sel == SEL_STAT);
        load       = we && (sel == SEL_DATA);
        rd_data    = re && (sel == SEL_DATA);
        start      = wr_ctrl && wdata[4] && wdata[6] && !busy;
        start_edge = wdata[7];

        ctrl_rd          = '0;
        ctrl_rd.edge_sel = edge_sel;
        ctrl_rd.enable   = enable;
        ctrl_rd.ovf      = ovf;
        ctrl_rd.go       = busy;
        ctrl_rd.hold     = hold;
        ctrl_rd.rate     = rate;

        rdata = '0;
        unique case (sel)
            SEL_CTRL: rdata = ctrl_rd;
            SEL_STAT: begin
                rdata[ST_MASTER] = master;
                rdata[ST_OD]     = od;
                rdata[ST_FULL]   = rx_full;
            end
            SEL_DATA: rdata = rx_q;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_sel <= 1'b0;
            enable   <= 1'b0;
            hold     <= 1'b0;
            rate     <= '0;
            master   <= 1'b0;
            od       <= 1'b0;
            rx_full  <= 1'b0;
            ovf      <= 1'b0;
            rx_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                edge_sel <= wdata[7];
                enable   <= wdata[6];
                hold     <= wdata[3];
                rate     <= wdata[RATE_W-1:0];
                if (!wdata[5]) begin
                    ovf <= 1'b0;
                end
            end
            if (wr_stat) begin
                master <= wdata[ST_MASTER];
                od     <= wdata[ST_OD];
            end
            if (rd_data) begin
                rx_full <= 1'b0;
            end
            if (done) begin
                if (!master && rx_full && !rd_data) begin
                    ovf <= 1'b1;
                end else begin
                    rx_q    <= rx_next;
                    rx_full <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             sck_out,
    output logic             sck_out_en,
    output logic             sck_opendrain,
    input  logic             sck_in,
    output logic             sdo_out,
    output logic             sdo_out_en,
    input  logic             sdi_in
);

    logic              cfg_edge;
    logic              cfg_en;
    logic              cfg_hold;
    logic [RATE_W-1:0] cfg_rate;
    logic              st_master;
    logic              st_od;
    logic              rx_full;
    logic              ovf_flag;
    logic              start;
    logic              start_edge;
    logic              load;
    logic              busy;
    logic              sck_lvl;
    logic              sdo_bit;
    logic              xfer_done;
    logic              tick;
    logic [REG_W-1:0]  rx_next;

    spi_reg_bank u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (bus_we),
        .re         (bus_re),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .busy       (busy),
        .done       (xfer_done),
        .rx_next    (rx_next),
        .edge_sel   (cfg_edge),
        .enable     (cfg_en),
        .hold       (cfg_hold),
        .rate       (cfg_rate),
        .master     (st_master),
        .od         (st_od),
        .rx_full    (rx_full),
        .ovf        (ovf_flag),
        .start      (start),
        .start_edge (start_edge),
        .load       (load),
        .rdata      (bus_rdata)
    );

    spi_sck_divider #(.RW(RATE_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy && cfg_en && st_master),
        .rate (cfg_rate),
        .tick (tick)
    );

    spi_shift_engine #(.DW(REG_W), .SYNC_N(SYNC_N)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg_en),
        .master     (st_master),
        .edge_sel   (cfg_edge),
        .start      (start),
        .start_edge (start_edge),
        .load       (load),
        .load_data  (bus_wdata),
        .tick       (tick),
        .sck_pin    (sck_in),
        .sdi_pin    (sdi_in),
        .busy       (busy),
        .sck_lvl    (sck_lvl),
        .sdo_bit    (sdo_bit),
        .done       (xfer_done),
        .rx_next    (rx_next)
    );

    always_comb begin
        sck_out       = sck_lvl;
        sck_out_en    = cfg_en && st_master;
        sck_opendrain = st_od;
        sdo_out       = sdo_bit;
        sdo_out_en    = cfg_en && (busy || cfg_hold);
    end

endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic en,
    input logic edge_sel,
    input logic master,
    input logic sck_out,
    input logic rx_full,
    input logic ovf,
    input logic done
);

    // R3: idle SCK rests at the selected level
    p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && $stable(edge_sel)) |-> (sck_out == edge_sel));

    // R4: go drops after the last sampling edge
    p_go_clears_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R5: clearing enable stops a transfer
    p_disable_stops_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy || en));

    // R6: a completed byte always leaves the buffer full
    p_full_after_byte_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_full);

    // R7: no overflow can appear in master mode
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (master && !ovf) |=> !ovf);

    // R7: overflow only rises over a full buffer
    p_ovf_needs_full_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> rx_full);

endmodule

bind spi_byte_port spi_byte_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .en       (cfg_en),
    .edge_sel (cfg_edge),
    .master   (st_master),
    .sck_out  (sck_out),
    .rx_full  (rx_full),
    .ovf      (ovf_flag),
    .done     (xfer_done)
);

// File: tb/spi_byte_port_bench.sv
module spi_byte_port_bench;

    localparam int CLK_P = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sck_out, sck_out_en, sck_opendrain, sdo_out, sdo_out_en;
    logic       sck_drv = 1'b0;
    logic       sdi_drv = 1'b0;
    logic       loopback = 1'b0;
    logic       sdi_in;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    assign sdi_in = loopback ? sdo_out : sdi_drv;

    always #(CLK_P/2) clk = ~clk;

    spi_byte_port u_spi_byte_port (
        .clk           (clk),
        .rst           (rst),
        .bus_we        (bus_we),
        .bus_re        (bus_re),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .sck_out       (sck_out),
        .sck_out_en    (sck_out_en),
        .sck_opendrain (sck_opendrain),
        .sck_in        (sck_drv),
        .sdo_out       (sdo_out),
        .sdo_out_en    (sdo_out_en),
        .sdi_in        (sdi_in)
    );

    function automatic logic [7:0] ctrl_word(input bit edg, input bit en, input bit keep_ovf,
                                             input bit go, input bit hold, input logic [2:0] rate);
        return {edg, en, keep_ovf, go, hold, rate};
    endfunction

    function automatic int half_of(input logic [2:0] rate);
        return 1 << rate;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic master_run(input bit edg, input logic [2:0] rate, input logic [7:0] tx,
                              input bit read_back, output logic [7:0] rx);
        logic [7:0] cap = 8'h00;
        logic [7:0] r;
        int  edges = 0;
        int  gap = 0;
        bit  pok = 1'b1;
        logic prev;
        loopback = 1'b1;
        bus_write(2'd1, 8'h80);
        bus_write(2'd2, tx);
        bus_write(2'd0, ctrl_word(edg, 1'b1, 1'b1, 1'b1, 1'b0, rate));
        prev = sck_out;
        check(prev == edg, "R3 idle level at start", prev, edg);
        for (int c = 0; c < 6000 && edges < 16; c++) begin
            @(negedge clk);
            if (sck_out !== prev) begin
                if (edges > 0 && gap != half_of(rate)) pok = 1'b0;
                if (sck_out == edg) cap = {cap[6:0], sdo_out};
                edges++;
                gap = 1;
                prev = sck_out;
            end else begin
                gap++;
            end
        end
        repeat (3) @(negedge clk);
        check(edges == 16, "R2 edge count", edges, 16);
        check(pok, "R2 half period", rate, half_of(rate));
        check(cap == tx, "R2 MSB-first SDO", cap, tx);
        check(sck_out == edg, "R3 idle level after byte", sck_out, edg);
        bus_read(2'd0, r);
        check(r[4] == 1'b0, "R4 go cleared", r[4], 0);
        rx = 8'h00;
        if (read_back) begin
            bus_read(2'd1, r);
            check(r[0] == 1'b1, "R6 full set", r[0], 1);
            bus_read(2'd2, rx);
        end
    endtask

    task automatic slave_run(input bit edg, input logic [7:0] tx, input logic [7:0] din,
                             output logic [7:0] cap);
        loopback = 1'b0;
        bus_write(2'd1, 8'h00);
        sck_drv = edg;
        repeat (4) @(negedge clk);
        bus_write(2'd2, tx);
        bus_write(2'd0, ctrl_word(edg, 1'b1, 1'b1, 1'b1, 1'b0, 3'd7));
        cap = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sck_drv = ~edg;
            sdi_drv = din[7-i];
            repeat (8) @(negedge clk);
            cap = {cap[6:0], sdo_out};
            sck_drv = edg;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, rx, cap, tx, din, keep;
        bit edg;
        logic [2:0] rate;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(2'd0, r);
        check(r == 8'h00, "R1 ctrl reset", r, 8'h00);
        bus_read(2'd1, r);
        check(r == 8'h00, "R1 status reset", r, 8'h00);
        check(!sck_out_en && !sdo_out_en && !sck_opendrain, "R1 pins idle",
              {sck_out_en, sdo_out_en, sck_opendrain}, 0);

        // R5 go ignored while disabled
        bus_write(2'd1, 8'h80);
        bus_write(2'd0, ctrl_word(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0));
        repeat (20) @(negedge clk);
        bus_read(2'd0, r);
        check(r == 8'h08, "R5 go not set when disabled", r, 8'h08);
        check(!sck_out_en && !sdo_out_en, "R5 pins released", {sck_out_en, sdo_out_en}, 0);
        bus_read(2'd1, r);
        check(r[0] == 1'b0, "R5 no byte received", r[0], 0);

        // R2 R3 directed master cases
        master_run(1'b0, 3'd0, 8'hA5, 1'b1, rx);
        check(rx == 8'hA5, "R6 loopback byte", rx, 8'hA5);
        master_run(1'b1, 3'd2, 8'h3C, 1'b1, rx);
        check(rx == 8'h3C, "R6 loopback byte idle high", rx, 8'h3C);
        bus_read(2'd1, r);
        check(r[0] == 1'b0, "R6 full cleared by data read", r[0], 0);
        check(r[1] == 1'b0, "R6 status bit1 zero", r[1], 0);

        // R4 R8 slow transfer, write during it ignored
        bus_write(2'd2, 8'h81);
        bus_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd7));
        bus_read(2'd0, r);
        check(r[4] == 1'b1, "R4 go reads 1 while busy", r[4], 1);
        bus_write(2'd2, 8'h00);
        for (int k = 0; k < 3000; k++) begin
            bus_read(2'd0, r);
            if (r[4] == 1'b0) break;
        end
        check(r[4] == 1'b0, "R4 go clears", r[4], 0);
        bus_read(2'd2, rx);
        check(rx == 8'h81, "R8 write during transfer ignored", rx, 8'h81);

        // R7 master overwrite, no overflow
        master_run(1'b0, 3'd1, 8'h11, 1'b0, rx);
        master_run(1'b0, 3'd1, 8'h22, 1'b0, rx);
        bus_read(2'd0, r);
        check(r[5] == 1'b0, "R7 no overflow in master", r[5], 0);
        bus_read(2'd2, rx);
        check(rx == 8'h22, "R7 master overwrites buffer", rx, 8'h22);

        // R10 slave exchanges
        slave_run(1'b0, 8'hC3, 8'h5A, cap);
        check(cap == 8'hC3, "R10 slave SDO", cap, 8'hC3);
        bus_read(2'd0, r);
        check(r[4] == 1'b0, "R10 slave go cleared", r[4], 0);
        bus_read(2'd2, rx);
        check(rx == 8'h5A, "R10 slave received", rx, 8'h5A);
        slave_run(1'b1, 8'h96, 8'hE1, cap);
        check(cap == 8'h96, "R10 slave SDO idle high", cap, 8'h96);
        keep = 8'hE1;

        // R7 slave overflow: buffer still holds E1
        slave_run(1'b0, 8'h00, 8'h99, cap);
        bus_read(2'd0, r);
        check(r[5] == 1'b1, "R7 overflow set", r[5], 1);
        bus_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0));
        bus_read(2'd0, r);
        check(r[5] == 1'b0, "R7 overflow cleared", r[5], 0);
        bus_read(2'd2, rx);
        check(rx == keep, "R7 buffer kept after overflow", rx, keep);

        // R9 SDO hold
        bus_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0));
        @(negedge clk);
        check(!sdo_out_en, "R9 SDO released when idle", sdo_out_en, 0);
        bus_write(2'd0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0));
        @(negedge clk);
        check(sdo_out_en, "R9 SDO held when idle", sdo_out_en, 1);

        // R11 open-drain bit, R6 read-only bits
        bus_write(2'd1, 8'h04);
        @(negedge clk);
        check(sck_opendrain, "R11 open-drain output", sck_opendrain, 1);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, r);
        check(r == 8'h84, "R11 R6 status mask", r, 8'h84);
        bus_write(2'd1, 8'h00);
        @(negedge clk);
        check(!sck_opendrain, "R11 open-drain off", sck_opendrain, 0);

        // random master and slave exchanges
        for (int n = 0; n < 8; n++) begin
            edg  = 1'($urandom);
            rate = 3'($urandom % 4);
            tx   = 8'($urandom);
            master_run(edg, rate, tx, 1'b1, rx);
            check(rx == tx, "R2 random loopback", rx, tx);
        end
        for (int n = 0; n < 4; n++) begin
            edg = 1'($urandom);
            tx  = 8'($urandom);
            din = 8'($urandom);
            slave_run(edg, tx, din, cap);
            check(cap == tx, "R10 random slave SDO", cap, tx);
            bus_read(2'd2, rx);
            check(rx == din, "R10 random slave received", rx, din);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule